// File: doc/BRIEF.md
# USB Function Interrupt Flag and Enable Bank

This block collects single-cycle event pulses from a USB function protocol engine and holds them as sticky flag bits that software reads over a simple CPU register bus. Each flag has a matching enable bit. A registered, level-sensitive interrupt request goes to the CPU while any enabled flag is set. A flag stays set until software clears it by writing 0 to that bit. Bits written with 1 keep their value, so one flag can be cleared without disturbing the others.

There are two flag groups, each with its own enable register. The bus-state group holds the wake and suspend flags. It also holds a configuration-valid status bit that comes out of reset at 1 and cannot be changed. The endpoint group holds the endpoint-3 transfer-request flag, the endpoint-3 transmit-complete flag, and a VBUS change flag. The VBUS input is synchronized, and both of its edges set the VBUS change flag. A write and a read use the same address. Reads are combinational from the address.

Top module: `usb_irq_flags`

## Requirements
- R1: After reset, address 0 reads 0x20, and addresses 1, 2 and 3 read 0x00. irq_o is 0.
- R2: A pulse on ep3_in_empty_i sets bit 2 of address 2. A pulse on ep3_ack_i sets bit 1 of address 2. Both take effect at the clock edge that samples the pulse, and the flag then holds until it is cleared.
- R3: A bus write to flag address 0 or 2 clears each implemented flag whose written bit is 0. A flag whose written bit is 1 keeps its value.
- R4: If a set event and a clearing write reach the same flag in the same cycle, the flag ends the cycle set.
- R5: Bit 5 of address 0 (configuration valid) always reads 1 and ignores writes. Bits 7, 6 and 4 of address 0 always read 0, as do bits 7 to 3 of address 2.
- R6: A pulse on wake_ev_i sets bit 3 of address 0 only when susp_ctrl_i is 1. Otherwise it has no effect.
- R7: A pulse on suspend_ev_i sets bit 2 of address 0 only when susp_ctrl_i is 1. Otherwise it has no effect.
- R8: Every change of vbus_i, rising or falling, sets bit 0 of address 2. The flag becomes visible after the third rising clock edge following the change, because of two synchronizer stages and one edge stage.
- R9: Address 1 and address 3 are read/write enable registers. Only bits 3 and 2 are stored at address 1, and only bits 2 to 0 at address 3. All other bits read 0.
- R10: irq_o is 1 in the cycle after some flag and its matching enable bit are both 1, and 0 otherwise. The configuration-valid bit never raises irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| wr_en_i | input | 1 | Bus write strobe, one write per cycle |
| addr_i | input | 2 | Register address (0 bus flags, 1 bus enables, 2 endpoint flags, 3 endpoint enables) |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Read data for addr_i |
| susp_ctrl_i | input | 1 | Suspend control bit, which qualifies wake and suspend events |
| wake_ev_i | input | 1 | Pulse: resume or bus reset seen on the bus |
| suspend_ev_i | input | 1 | Pulse: suspend condition seen on the bus |
| ep3_in_empty_i | input | 1 | Pulse: IN token for endpoint 3 with no valid transmit data |
| ep3_ack_i | input | 1 | Pulse: endpoint 3 packet acknowledged by host |
| vbus_i | input | 1 | Asynchronous VBUS sense pin |
| irq_o | output | 1 | Registered level interrupt request |

## Verification
The bench targets four cases:
- A clearing write that coincides with a set event. A design where the clear wins would lose an interrupt.
- Wake and suspend pulses with the suspend control low. A design that does not gate them would raise flags that should stay 0.
- Both VBUS directions, checked at the exact latency. A design that detects only rising edges would miss a disconnect, and one with the wrong number of stages would shift the flag by a cycle.
- Writes of all zeros and all ones to the flag addresses. These would expose a configuration bit or reserved bit that can be written, and an interrupt that is driven combinationally or that counts the status bit.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_BUS_FLAG = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_BUS_EN   = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_EP_FLAG  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_EP_EN    = 2'd3;

  // bus-state group bit positions
  localparam int unsigned BIT_CFG   = 5;
  localparam int unsigned BIT_WAKE  = 3;
  localparam int unsigned BIT_SUSP  = 2;
  // endpoint group bit positions
  localparam int unsigned BIT_EPREQ = 2;
  localparam int unsigned BIT_EPTX  = 1;
  localparam int unsigned BIT_VBUS  = 0;

  localparam logic [DATA_W-1:0] BUS_FLAG_MASK = (DATA_W'(1) << BIT_WAKE) | (DATA_W'(1) << BIT_SUSP);
  localparam logic [DATA_W-1:0] BUS_FIXED     = DATA_W'(1) << BIT_CFG;
  localparam logic [DATA_W-1:0] EP_FLAG_MASK  = (DATA_W'(1) << BIT_EPREQ) | (DATA_W'(1) << BIT_EPTX)
                                              | (DATA_W'(1) << BIT_VBUS);
  localparam logic [DATA_W-1:0] EP_FIXED      = '0;
endpackage

// File: rtl/usb_vbus_edge.sv
module usb_vbus_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vbus_i,
  output logic edge_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= vbus_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[g] <= 1'b0;
          else         sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[SYNC_STAGES-1];
  end

  // both connect and disconnect are reported
  assign edge_o = sync_q[SYNC_STAGES-1] ^ last_q;
endmodule

// File: rtl/usb_flag_bank.sv
module usb_flag_bank #(
  parameter int unsigned          WIDTH = 8,
  parameter logic [WIDTH-1:0]     IMPL  = '1,
  parameter logic [WIDTH-1:0]     FIXED = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] set_i,
  output logic [WIDTH-1:0] flag_o
);
  logic [WIDTH-1:0] q;

  genvar g;
  generate
    for (g = 0; g < WIDTH; g++) begin : g_bit
      if (FIXED[g]) begin : g_one
        assign q[g] = 1'b1;
      end else if (IMPL[g]) begin : g_flag
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)    q[g] <= 1'b0;
          else if (set_i[g]) q[g] <= 1'b1;             // set beats clear
          else if (wr_i && !wdata_i[g]) q[g] <= 1'b0;
        end
      end else begin : g_zero
        assign q[g] = 1'b0;
      end
    end
  endgenerate

  assign flag_o = q;

  p_sticky_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(set_i & IMPL) |=> ((flag_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && set_i == '0) |=> $stable(flag_o));

  p_wr_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && set_i == '0) |=> ((flag_o & IMPL & ~FIXED) == ($past(flag_o) & $past(wdata_i) & IMPL & ~FIXED)));
endmodule

// File: rtl/usb_en_reg.sv
module usb_en_reg #(
  parameter int unsigned      WIDTH = 8,
  parameter logic [WIDTH-1:0] IMPL  = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] en_o
);
  logic [WIDTH-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q <= '0;
    else if (wr_i) q <= wdata_i & IMPL;
  end

  assign en_o = q;

  p_en_unimpl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o & ~IMPL) == '0);
endmodule

// File: rtl/usb_irq_merge.sv
module usb_irq_merge #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned GROUPS = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [GROUPS-1:0][WIDTH-1:0] flag_i,
  input  logic [GROUPS-1:0][WIDTH-1:0] en_i,
  input  logic [GROUPS-1:0][WIDTH-1:0] src_mask_i,
  output logic                         irq_o
);
  logic [GROUPS-1:0] grp_hit;
  logic              irq_q;

  genvar g;
  generate
    for (g = 0; g < GROUPS; g++) begin : g_grp
      assign grp_hit[g] = |(flag_i[g] & en_i[g] & src_mask_i[g]);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |grp_hit;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/usb_irq_flags.sv
module usb_irq_flags
  import usb_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              susp_ctrl_i,
  input  logic              wake_ev_i,
  input  logic              suspend_ev_i,
  input  logic              ep3_in_empty_i,
  input  logic              ep3_ack_i,
  input  logic              vbus_i,
  output logic              irq_o
);
  logic              vbus_edge;
  logic [DATA_W-1:0] bus_set, ep_set;
  logic [DATA_W-1:0] bus_flag, ep_flag, bus_en, ep_en;
  logic              wr_bus_flag, wr_bus_en, wr_ep_flag, wr_ep_en;

  assign wr_bus_flag = wr_en_i && addr_i == ADR_BUS_FLAG;
  assign wr_bus_en   = wr_en_i && addr_i == ADR_BUS_EN;
  assign wr_ep_flag  = wr_en_i && addr_i == ADR_EP_FLAG;
  assign wr_ep_en    = wr_en_i && addr_i == ADR_EP_EN;

  usb_vbus_edge #(.SYNC_STAGES(2)) u_vbus (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vbus_i (vbus_i),
    .edge_o (vbus_edge)
  );

  always_comb begin
    bus_set = '0;
    bus_set[BIT_WAKE] = wake_ev_i    && susp_ctrl_i;
    bus_set[BIT_SUSP] = suspend_ev_i && susp_ctrl_i;
    ep_set  = '0;
    ep_set[BIT_EPREQ] = ep3_in_empty_i;
    ep_set[BIT_EPTX]  = ep3_ack_i;
    ep_set[BIT_VBUS]  = vbus_edge;
  end

  usb_flag_bank #(.WIDTH(DATA_W), .IMPL(BUS_FLAG_MASK), .FIXED(BUS_FIXED)) u_bus_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_bus_flag),
    .wdata_i (wdata_i),
    .set_i   (bus_set),
    .flag_o  (bus_flag)
  );

  usb_flag_bank #(.WIDTH(DATA_W), .IMPL(EP_FLAG_MASK), .FIXED(EP_FIXED)) u_ep_flag (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ep_flag),
    .wdata_i (wdata_i),
    .set_i   (ep_set),
    .flag_o  (ep_flag)
  );

  usb_en_reg #(.WIDTH(DATA_W), .IMPL(BUS_FLAG_MASK)) u_bus_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_bus_en),
    .wdata_i (wdata_i),
    .en_o    (bus_en)
  );

  usb_en_reg #(.WIDTH(DATA_W), .IMPL(EP_FLAG_MASK)) u_ep_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_ep_en),
    .wdata_i (wdata_i),
    .en_o    (ep_en)
  );

  logic [1:0][DATA_W-1:0] irq_flags, irq_ens, irq_srcs;
  assign irq_flags = {ep_flag, bus_flag};
  assign irq_ens   = {ep_en, bus_en};
  assign irq_srcs  = {EP_FLAG_MASK, BUS_FLAG_MASK};  // status bit excluded

  usb_irq_merge #(.WIDTH(DATA_W), .GROUPS(2)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flag_i     (irq_flags),
    .en_i       (irq_ens),
    .src_mask_i (irq_srcs),
    .irq_o      (irq_o)
  );

  always_comb begin
    unique case (addr_i)
      ADR_BUS_FLAG: rdata_o = bus_flag;
      ADR_BUS_EN:   rdata_o = bus_en;
      ADR_EP_FLAG:  rdata_o = ep_flag;
      default:      rdata_o = ep_en;
    endcase
  end

  p_wake_gated_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_flag[BIT_WAKE]) |-> $past(wake_ev_i && susp_ctrl_i));

  p_susp_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_flag[BIT_SUSP]) |-> $past(suspend_ev_i && susp_ctrl_i));

  p_reserved_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADR_BUS_FLAG) |-> (rdata_o[7:6] == 2'b00 && !rdata_o[4] && rdata_o[BIT_CFG]));

  p_irq_lag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(|(bus_flag & bus_en & BUS_FLAG_MASK) || |(ep_flag & ep_en)));

  p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ep_flag && ep3_in_empty_i) |=> ep_flag[BIT_EPREQ]);
endmodule

// File: tb/usb_irq_flags_tb.sv
module usb_irq_flags_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic susp_ctrl = 1'b0, wake_ev = 1'b0, susp_ev = 1'b0;
  logic ep_empty = 1'b0, ep_ack = 1'b0, vbus = 1'b0;
  logic irq;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_irq_flags u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .susp_ctrl_i(susp_ctrl), .wake_ev_i(wake_ev), .suspend_ev_i(susp_ev),
    .ep3_in_empty_i(ep_empty), .ep3_ack_i(ep_ack), .vbus_i(vbus), .irq_o(irq)
  );

  // behavioural reference model
  int m_reg[4];
  int m_irq;
  int m_vq[$];   // vbus pipeline, oldest first
  int m_last;

  task automatic model_reset();
    m_reg[0] = 'h20; m_reg[1] = 0; m_reg[2] = 0; m_reg[3] = 0;
    m_irq = 0; m_last = 0;
    m_vq = {0, 0};
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int old[4];
      int vb_chg, set_a, set_b, pend;
      foreach (old[i]) old[i] = m_reg[i];
      vb_chg = (m_vq[0] != m_last) ? 1 : 0;
      pend = (((old[0] & old[1] & 'h0C) != 0) || ((old[2] & old[3] & 'h07) != 0)) ? 1 : 0;
      set_a = ((wake_ev && susp_ctrl) ? 8 : 0) + ((susp_ev && susp_ctrl) ? 4 : 0);
      set_b = (ep_empty ? 4 : 0) + (ep_ack ? 2 : 0) + vb_chg;
      if (wr_en && addr == 1) m_reg[1] = wdata & 'h0C;
      if (wr_en && addr == 3) m_reg[3] = wdata & 'h07;
      m_reg[0] = (((wr_en && addr == 0) ? (old[0] & wdata) : old[0]) | set_a) & 'h0C | 'h20;
      m_reg[2] = (((wr_en && addr == 2) ? (old[2] & wdata) : old[2]) | set_b) & 'h07;
      m_irq = pend;
      m_last = m_vq[0];
      void'(m_vq.pop_front());
      m_vq.push_back(int'(vbus));
    end
  end

  // per-cycle irq comparison
  always @(negedge clk) if (rst_n) begin
    checks++;
    if (int'(irq) != m_irq) begin
      fails++;
      $display("FAIL R10 irq_o act=%0d exp=%0d at %0t", irq, m_irq, $time);
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic rd(input string req, input logic [1:0] a);
    addr = a;
    #1;
    chk(req, int'(rdata), m_reg[a]);
  endtask

  task automatic rd_exp(input string req, input logic [1:0] a, input int exp);
    addr = a;
    #1;
    chk(req, int'(rdata), exp);
  endtask

  // one-cycle bus write; pulses set beforehand land in the same cycle
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wake_ev = 0; susp_ev = 0; ep_empty = 0; ep_ack = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      wake_ev = 0; susp_ev = 0; ep_empty = 0; ep_ack = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks + 0);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd_exp("R1", 0, 'h20); rd_exp("R1", 1, 0); rd_exp("R1", 2, 0); rd_exp("R1", 3, 0);
    chk("R1 irq", int'(irq), 0);

    // R9 enables keep implemented bits only
    wr(1, 8'hFF); rd_exp("R9", 1, 'h0C);
    wr(3, 8'hFF); rd_exp("R9", 3, 'h07);

    // R2 sticky endpoint flags
    ep_empty = 1; tick(1); rd_exp("R2", 2, 'h04);
    chk("R10 irq one cycle later", int'(irq), 0);
    tick(1); chk("R10 irq asserted", int'(irq), 1);
    ep_ack = 1; tick(1); tick(3); rd_exp("R2", 2, 'h06);

    // R3 write-0 clears, write-1 keeps
    wr(2, 8'hFD); rd_exp("R3", 2, 'h04);
    wr(2, 8'hFF); rd_exp("R3", 2, 'h04);
    wr(2, 8'h00); rd_exp("R3", 2, 'h00);
    tick(1); chk("R10 irq drops", int'(irq), 0);

    // R4 set wins over same-cycle clear
    wr(2, 8'hFF); ep_empty = 1; ep_ack = 0;
    ep_ack = 1; wr(2, 8'hF9); rd_exp("R4", 2, 'h06);
    wr(2, 8'h00); rd_exp("R4", 2, 0);

    // R6/R7 gated by suspend control
    susp_ctrl = 0; wake_ev = 1; susp_ev = 1; tick(1); rd_exp("R6", 0, 'h20);
    susp_ev = 1; tick(1); rd_exp("R7", 0, 'h20);
    susp_ctrl = 1; wake_ev = 1; tick(1); rd_exp("R6", 0, 'h28);
    susp_ev = 1; tick(1); rd_exp("R7", 0, 'h2C);
    tick(1); chk("R10 bus flags", int'(irq), 1);

    // R5 status bit and reserved bits
    wr(0, 8'hF7); rd_exp("R5", 0, 'h24);
    wr(0, 8'h00); rd_exp("R5", 0, 'h20);
    wr(0, 8'hFF); rd_exp("R5", 0, 'h20);
    wr(2, 8'hFF); rd_exp("R5", 2, 'h00);
    wr(1, 8'h20); rd_exp("R10 cfg masked", 1, 0);
    tick(2); chk("R10 cfg no irq", int'(irq), 0);

    // R8 VBUS both edges, exact latency
    susp_ctrl = 0;
    vbus = 1; tick(2); rd_exp("R8", 2, 0);
    tick(1); rd_exp("R8", 2, 'h01);
    wr(2, 8'h00); rd_exp("R8", 2, 0);
    vbus = 0; tick(2); rd_exp("R8", 2, 0);
    tick(1); rd_exp("R8", 2, 'h01);
    tick(1); chk("R10 vbus irq", int'(irq), 1);
    wr(3, 8'h00); tick(2); chk("R10 disabled", int'(irq), 0);
    rd("R8", 2);

    tick(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule